// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

The arbiter merges interrupt requests from a row of expansion-card slots with a fixed group of system-board interrupt sources. It presents one pending priority level and one vector to the processor core. It also raises a take strobe when the pending level is above the processor's current priority, and it supplies the address of the vector-table word to fetch. Each card slot posts a request with a one-cycle raise pulse. The slot stores the level and vector given with the pulse and keeps its request until an acknowledge that matches it. Board sources are plain level flags.

Card slots always have priority over board sources. The lowest-numbered slot that has a request wins. Board sources have no vector of their own, so their level is used as the vector. A non-maskable request forces the dispatch vector to zero. Quick-interrupt dispatch is not supported: when it is requested, an error output replaces the take strobe.

Top module: `vec_irq_arbiter`

## Requirements
- R1: A raise pulse on slot s stores that slot's level and vector and sets its request. From the clock edge after the request is set, the lowest-numbered slot with a request drives `pend_lvl_o` and `pend_vec_o`.
- R2: While any slot has a request, the board sources have no effect on the pending level or vector.
- R3: With no slot request, the board sources are examined in a fixed order and the first active one is taken. The bits of `brd_src_i` and their levels are: bit0 soft request A gives level 8; bit1 soft request B gives 9; bit2 disk or bit3 floppy gives 11; bit4 UART or bit5 DMA gives 13; bit6 timer gives 15. The pending outputs follow a change of `brd_src_i` one clock edge later.
- R4: A board source sets the pending vector equal to its level. With no source active, the pending level and vector are both 0.
- R5: `take_o` is 1 only while `cur_ipl_i` is strictly less than `pend_lvl_o`, and quick mode is off.
- R6: After a `nmi_i` pulse, the dispatch vector is 0 until the next acknowledge, so `fetch_addr_o` equals 0x8C.
- R7: `fetch_addr_o` equals 0x8C plus 4 times the dispatch vector. The dispatch vector is `pend_vec_o` when no NMI is pending.
- R8: An `ack_i` pulse clears the request of every slot whose stored level and vector both equal `pend_lvl_o`/`pend_vec_o`. Slots with any other pair keep their requests.
- R9: In the cycle after `ack_i`, `pend_lvl_o` and `pend_vec_o` are 0 and the NMI flag is clear. The outputs are then recomputed on the following edge.
- R10: While `quick_mode_i` is 1, `take_o` stays 0. `quick_err_o` is 1 exactly when a dispatch would otherwise have been taken.
- R11: After reset, no slot request or NMI is pending, and the pending level and vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_raise_i | input | NUM_SLOTS | Per-slot one-cycle request pulse |
| slot_lvl_i | input | NUM_SLOTS*LVL_W | Per-slot level, slot s at bits [s*LVL_W +: LVL_W] |
| slot_vec_i | input | NUM_SLOTS*VEC_W | Per-slot vector, slot s at bits [s*VEC_W +: VEC_W] |
| brd_src_i | input | 7 | Board source flags (see R3) |
| cur_ipl_i | input | LVL_W | Current processor priority level |
| nmi_i | input | 1 | Pulse that marks a non-maskable request |
| quick_mode_i | input | 1 | Quick-interrupt dispatch requested |
| ack_i | input | 1 | One-cycle acknowledge of the dispatched pair |
| pend_lvl_o | output | LVL_W | Pending priority level |
| pend_vec_o | output | VEC_W | Pending vector |
| take_o | output | 1 | Take-interrupt strobe |
| quick_err_o | output | 1 | Quick-mode dispatch refused |
| fetch_addr_o | output | ADDR_W | Vector-table word address |

## Verification
The bench first walks the board flags from the weakest source to the strongest. Each step adds one flag, so it shows that the fixed order wins over the numeric level. Single floppy and DMA flags confirm that the shared levels are combined. A low-level card request raised on top of active board flags separates "card first" from "highest level first". A second card in a lower-numbered slot separates slot order from arrival order. Two slots holding the same pair, next to a third slot with a different pair, show that acknowledge clears by pair and not only the winning slot. Priority levels equal to and just below the pending level show that the comparison is strict. The NMI and quick-mode cases show that the dispatch address and the strobe are overridden while the pending pair is left unchanged.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
   localparam int BRD_N      = 7;
   localparam int SRC_SOFT_A = 0;
   localparam int SRC_SOFT_B = 1;
   localparam int SRC_DISK   = 2;
   localparam int SRC_FLOP   = 3;
   localparam int SRC_UART   = 4;
   localparam int SRC_DMA    = 5;
   localparam int SRC_TIMER  = 6;

   localparam int LVL_SOFT_A = 8;
   localparam int LVL_SOFT_B = 9;
   localparam int LVL_STORE  = 11;
   localparam int LVL_COMMS  = 13;
   localparam int LVL_TIMER  = 15;

   typedef enum logic [1:0] {
      PICK_NONE  = 2'd0,
      PICK_CARD  = 2'd1,
      PICK_BOARD = 2'd2
   } pick_e;
endpackage

// File: rtl/irqarb_slot_bank.sv
module irqarb_slot_bank #(
   parameter int NUM_SLOTS = 12,
   parameter int LVL_W     = 4,
   parameter int VEC_W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SLOTS-1:0]       raise_i,
   input  logic [NUM_SLOTS*LVL_W-1:0] lvl_i,
   input  logic [NUM_SLOTS*VEC_W-1:0] vec_i,
   input  logic                       ack_i,
   input  logic [LVL_W-1:0]           ack_lvl_i,
   input  logic [VEC_W-1:0]           ack_vec_i,
   output logic [NUM_SLOTS-1:0]       req_o,
   output logic [NUM_SLOTS*LVL_W-1:0] lvl_o,
   output logic [NUM_SLOTS*VEC_W-1:0] vec_o
);
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic             req_q;
      logic [LVL_W-1:0] lvl_q;
      logic [VEC_W-1:0] vec_q;
      logic             hit;

      assign hit = ack_i && req_q && (lvl_q == ack_lvl_i) && (vec_q == ack_vec_i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q <= 1'b0;
            lvl_q <= '0;
            vec_q <= '0;
         end else if (raise_i[s]) begin
            req_q <= 1'b1;
            lvl_q <= lvl_i[s*LVL_W +: LVL_W];
            vec_q <= vec_i[s*VEC_W +: VEC_W];
         end else if (hit) begin
            req_q <= 1'b0;
         end
      end

      assign req_o[s]                 = req_q;
      assign lvl_o[s*LVL_W +: LVL_W]  = lvl_q;
      assign vec_o[s*VEC_W +: VEC_W]  = vec_q;
   end
endmodule

// File: rtl/irqarb_card_pick.sv
module irqarb_card_pick #(
   parameter int NUM_SLOTS = 12,
   parameter int LVL_W     = 4,
   parameter int VEC_W     = 8
) (
   input  logic [NUM_SLOTS-1:0]       req_i,
   input  logic [NUM_SLOTS*LVL_W-1:0] lvl_i,
   input  logic [NUM_SLOTS*VEC_W-1:0] vec_i,
   output logic                       hit_o,
   output logic [LVL_W-1:0]           lvl_o,
   output logic [VEC_W-1:0]           vec_o
);
   if (NUM_SLOTS == 1) begin : g_single
      assign hit_o = req_i[0];
      assign lvl_o = lvl_i;
      assign vec_o = vec_i;
   end else begin : g_scan
      always_comb begin
         hit_o = 1'b0;
         lvl_o = '0;
         vec_o = '0;
         for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (req_i[s]) begin
               hit_o = 1'b1;
               lvl_o = lvl_i[s*LVL_W +: LVL_W];
               vec_o = vec_i[s*VEC_W +: VEC_W];
            end
         end
      end
   end
endmodule

// File: rtl/irqarb_board_pick.sv
module irqarb_board_pick
   import irqarb_pkg::*;
#(
   parameter int LVL_W = 4
) (
   input  logic [BRD_N-1:0] src_i,
   output logic             hit_o,
   output logic [LVL_W-1:0] lvl_o
);
   always_comb begin
      hit_o = 1'b1;
      if (src_i[SRC_SOFT_A])
         lvl_o = LVL_W'(LVL_SOFT_A);
      else if (src_i[SRC_SOFT_B])
         lvl_o = LVL_W'(LVL_SOFT_B);
      else if (src_i[SRC_DISK] || src_i[SRC_FLOP])
         lvl_o = LVL_W'(LVL_STORE);
      else if (src_i[SRC_UART] || src_i[SRC_DMA])
         lvl_o = LVL_W'(LVL_COMMS);
      else if (src_i[SRC_TIMER])
         lvl_o = LVL_W'(LVL_TIMER);
      else begin
         hit_o = 1'b0;
         lvl_o = '0;
      end
   end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
   import irqarb_pkg::*;
#(
   parameter int          NUM_SLOTS = 12,
   parameter int          LVL_W     = 4,
   parameter int          VEC_W     = 8,
   parameter int          ADDR_W    = 16,
   parameter logic [31:0] VTAB_BASE = 32'h8C
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SLOTS-1:0]       slot_raise_i,
   input  logic [NUM_SLOTS*LVL_W-1:0] slot_lvl_i,
   input  logic [NUM_SLOTS*VEC_W-1:0] slot_vec_i,
   input  logic [BRD_N-1:0]           brd_src_i,
   input  logic [LVL_W-1:0]           cur_ipl_i,
   input  logic                       nmi_i,
   input  logic                       quick_mode_i,
   input  logic                       ack_i,
   output logic [LVL_W-1:0]           pend_lvl_o,
   output logic [VEC_W-1:0]           pend_vec_o,
   output logic                       take_o,
   output logic                       quick_err_o,
   output logic [ADDR_W-1:0]          fetch_addr_o
);
   localparam int ADDR_NEED = $clog2(VTAB_BASE + (32'd1 << VEC_W) * 4);

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("vec_irq_arbiter: NUM_SLOTS must be at least 1");
   end
   if (LVL_W < 4) begin : g_bad_lvl
      $error("vec_irq_arbiter: LVL_W must hold board level 15");
   end
   if (VEC_W < LVL_W) begin : g_bad_vec
      $error("vec_irq_arbiter: VEC_W must be at least LVL_W");
   end
   if (ADDR_W < ADDR_NEED) begin : g_bad_addr
      $error("vec_irq_arbiter: ADDR_W too narrow for the vector table");
   end

   logic [NUM_SLOTS-1:0]       req;
   logic [NUM_SLOTS*LVL_W-1:0] st_lvl;
   logic [NUM_SLOTS*VEC_W-1:0] st_vec;
   logic                       card_hit, brd_hit;
   logic [LVL_W-1:0]           card_lvl, brd_lvl;
   logic [VEC_W-1:0]           card_vec;
   logic [LVL_W-1:0]           pend_lvl_q;
   logic [VEC_W-1:0]           pend_vec_q;
   logic                       nmi_q;
   logic [VEC_W-1:0]           disp_vec;
   logic                       above;
   pick_e                      pick;

   irqarb_slot_bank #(
      .NUM_SLOTS(NUM_SLOTS), .LVL_W(LVL_W), .VEC_W(VEC_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .raise_i   (slot_raise_i),
      .lvl_i     (slot_lvl_i),
      .vec_i     (slot_vec_i),
      .ack_i     (ack_i),
      .ack_lvl_i (pend_lvl_q),
      .ack_vec_i (pend_vec_q),
      .req_o     (req),
      .lvl_o     (st_lvl),
      .vec_o     (st_vec)
   );

   irqarb_card_pick #(
      .NUM_SLOTS(NUM_SLOTS), .LVL_W(LVL_W), .VEC_W(VEC_W)
   ) u_card (
      .req_i (req),
      .lvl_i (st_lvl),
      .vec_i (st_vec),
      .hit_o (card_hit),
      .lvl_o (card_lvl),
      .vec_o (card_vec)
   );

   irqarb_board_pick #(.LVL_W(LVL_W)) u_board (
      .src_i (brd_src_i),
      .hit_o (brd_hit),
      .lvl_o (brd_lvl)
   );

   always_comb begin
      if (card_hit)     pick = PICK_CARD;
      else if (brd_hit) pick = PICK_BOARD;
      else              pick = PICK_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_lvl_q <= '0;
         pend_vec_q <= '0;
      end else if (ack_i) begin
         pend_lvl_q <= '0;
         pend_vec_q <= '0;
      end else begin
         case (pick)
            PICK_CARD: begin
               pend_lvl_q <= card_lvl;
               pend_vec_q <= card_vec;
            end
            PICK_BOARD: begin
               pend_lvl_q <= brd_lvl;
               pend_vec_q <= VEC_W'(brd_lvl);
            end
            default: begin
               pend_lvl_q <= '0;
               pend_vec_q <= '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      nmi_q <= 1'b0;
      else if (nmi_i)  nmi_q <= 1'b1;
      else if (ack_i)  nmi_q <= 1'b0;
   end

   assign disp_vec     = nmi_q ? '0 : pend_vec_q;
   assign above        = cur_ipl_i < pend_lvl_q;
   assign take_o       = above && !quick_mode_i;
   assign quick_err_o  = above && quick_mode_i;
   assign fetch_addr_o = ADDR_W'(VTAB_BASE) + (ADDR_W'(disp_vec) << 2);
   assign pend_lvl_o   = pend_lvl_q;
   assign pend_vec_o   = pend_vec_q;
endmodule

// File: rtl/vec_irq_arbiter_chk.sv
module vec_irq_arbiter_chk #(
   parameter int          LVL_W     = 4,
   parameter int          VEC_W     = 8,
   parameter int          ADDR_W    = 16,
   parameter logic [31:0] VTAB_BASE = 32'h8C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_i,
   input logic              nmi_i,
   input logic              quick_mode_i,
   input logic [LVL_W-1:0]  pend_lvl_o,
   input logic [VEC_W-1:0]  pend_vec_o,
   input logic              take_o,
   input logic              quick_err_o,
   input logic [ADDR_W-1:0] fetch_addr_o
);
   // R5: a take needs a nonzero pending level
   a_r5_take_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (pend_lvl_o != '0));

   // R10: quick mode blocks the strobe
   a_r10_quick_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
      quick_mode_i |-> !take_o);

   // R10: error only while quick mode is requested
   a_r10_err_only_quick: assert property (@(posedge clk) disable iff (!rst_n)
      quick_err_o |-> quick_mode_i);

   // R9: acknowledge zeroes the pending pair
   a_r9_ack_zeroes_pair: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> (pend_lvl_o == '0) && (pend_vec_o == '0));

   // R6: NMI forces the table base as fetch address
   a_r6_nmi_forces_base: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_i |=> (fetch_addr_o == ADDR_W'(VTAB_BASE)));

   // R7: fetch address keeps word alignment of the table
   a_r7_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_addr_o[1:0] == VTAB_BASE[1:0]);
endmodule

bind vec_irq_arbiter vec_irq_arbiter_chk #(
   .LVL_W(LVL_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .VTAB_BASE(VTAB_BASE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ack_i        (ack_i),
   .nmi_i        (nmi_i),
   .quick_mode_i (quick_mode_i),
   .pend_lvl_o   (pend_lvl_o),
   .pend_vec_o   (pend_vec_o),
   .take_o       (take_o),
   .quick_err_o  (quick_err_o),
   .fetch_addr_o (fetch_addr_o)
);

// File: tb/vec_irq_arbiter_tb.sv
`timescale 1ns/1ps
module vec_irq_arbiter_tb;
   localparam int NS = 12;
   localparam int LW = 4;
   localparam int VW = 8;
   localparam int AW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NS-1:0]   slot_raise = '0;
   logic [NS*LW-1:0] slot_lvl = '0;
   logic [NS*VW-1:0] slot_vec = '0;
   logic [6:0]      brd = '0;
   logic [LW-1:0]   cur_ipl = '0;
   logic            nmi = 1'b0;
   logic            quick = 1'b0;
   logic            ack = 1'b0;
   logic [LW-1:0]   pend_lvl;
   logic [VW-1:0]   pend_vec;
   logic            take;
   logic            qerr;
   logic [AW-1:0]   faddr;

   always #2.5 clk = ~clk;

   vec_irq_arbiter u_dut (
      .clk(clk), .rst_n(rst_n),
      .slot_raise_i(slot_raise), .slot_lvl_i(slot_lvl), .slot_vec_i(slot_vec),
      .brd_src_i(brd), .cur_ipl_i(cur_ipl), .nmi_i(nmi),
      .quick_mode_i(quick), .ack_i(ack),
      .pend_lvl_o(pend_lvl), .pend_vec_o(pend_vec), .take_o(take),
      .quick_err_o(qerr), .fetch_addr_o(faddr)
   );

   typedef struct packed {
      logic [LW-1:0] lvl;
      logic [VW-1:0] vec;
      logic          tk;
      logic          er;
      logic [AW-1:0] ad;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input string tag, input int l, input int v,
                       input bit tk, input bit er, input int ad);
      exp_t e;
      e.lvl = LW'(l); e.vec = VW'(v); e.tk = tk; e.er = er; e.ad = AW'(ad);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic raise(input int s, input int l, input int v);
      slot_lvl[s*LW +: LW] = LW'(l);
      slot_vec[s*VW +: VW] = VW'(v);
      slot_raise[s] = 1'b1;
      tick(1);
      slot_raise[s] = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      tick(1);
      ack = 1'b0;
   endtask

   // monitor: compares once outputs settle after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pend_lvl !== e.lvl || pend_vec !== e.vec || take !== e.tk ||
                qerr !== e.er || faddr !== e.ad) begin
               fails++;
               $display("FAIL %s actual lvl=%0d vec=%h take=%b err=%b addr=%h expected lvl=%0d vec=%h take=%b err=%b addr=%h",
                        t, pend_lvl, pend_vec, take, qerr, faddr,
                        e.lvl, e.vec, e.tk, e.er, e.ad);
            end
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(2);
      rst_n = 1'b1;
      tick(1);
      push("R11 reset", 0, 0, 0, 0, 'h8C);
      tick(1);

      // board order (R3, R4)
      brd = 7'b100_0000; tick(1);
      push("R4 timer vec=level", 15, 15, 1, 0, 'h8C + 60);
      tick(1);
      brd = 7'b101_0000; tick(1);
      push("R3 uart over timer", 13, 13, 1, 0, 'h8C + 52);
      tick(1);
      brd = 7'b000_1000; tick(1);
      push("R3 floppy level 11", 11, 11, 1, 0, 'h8C + 44);
      tick(1);
      brd = 7'b010_0000; tick(1);
      push("R3 dma level 13", 13, 13, 1, 0, 'h8C + 52);
      tick(1);
      brd = 7'b111_0010; tick(1);
      push("R3 soft B level 9", 9, 9, 1, 0, 'h8C + 36);
      tick(1);
      brd = 7'b111_0011; tick(1);
      push("R3 soft A first", 8, 8, 1, 0, 'h8C + 32);
      tick(1);

      // strict comparison (R5)
      cur_ipl = 4'd8; tick(0);
      push("R5 equal level no take", 8, 8, 0, 0, 'h8C + 32);
      tick(1);
      cur_ipl = 4'd7;
      push("R5 below level take", 8, 8, 1, 0, 'h8C + 32);
      tick(1);

      // cards over board (R2), slot order (R1)
      raise(5, 3, 'h40); tick(1);
      push("R2 card over board", 3, 'h40, 0, 0, 'h8C + 'h100);
      tick(1);
      raise(2, 10, 'h21); tick(1);
      push("R1 lowest slot wins", 10, 'h21, 1, 0, 'h8C + 'h84);
      tick(1);
      raise(9, 10, 'h21); tick(1);
      push("R1 slot 2 kept over 9", 10, 'h21, 1, 0, 'h8C + 'h84);
      tick(1);

      // acknowledge by pair (R8, R9)
      pulse_ack();
      push("R9 ack zeroes pair", 0, 0, 0, 0, 'h8C);
      tick(1);
      push("R8 matching slots cleared", 3, 'h40, 0, 0, 'h8C + 'h100);
      tick(1);
      pulse_ack();
      tick(1);
      push("R8 board returns after last card", 8, 8, 1, 0, 'h8C + 32);
      tick(1);

      // NMI (R6, R9)
      nmi = 1'b1; tick(1); nmi = 1'b0;
      push("R6 nmi forces vector 0", 8, 8, 1, 0, 'h8C);
      tick(1);
      push("R6 nmi held", 8, 8, 1, 0, 'h8C);
      pulse_ack();
      tick(1);
      push("R9 nmi cleared by ack", 8, 8, 1, 0, 'h8C + 32);
      tick(1);

      // quick mode (R10)
      quick = 1'b1; cur_ipl = 4'd0;
      push("R10 quick refuses take", 8, 8, 0, 1, 'h8C + 32);
      tick(1);
      cur_ipl = 4'd15;
      push("R10 no error below pending", 8, 8, 0, 0, 'h8C + 32);
      tick(1);
      quick = 1'b0; cur_ipl = 4'd0;

      // idle (R4)
      brd = '0; tick(1);
      push("R4 no source zero", 0, 0, 0, 0, 'h8C);
      tick(1);

      // address extreme (R7)
      raise(11, 15, 'hFF); tick(1);
      push("R7 top vector address", 15, 'hFF, 1, 0, 'h8C + 4 * 255);
      tick(1);
      raise(0, 6, 'h12); tick(1);
      push("R7 slot 0 address", 6, 'h12, 1, 0, 'h8C + 4 * 'h12);
      tick(1);
      pulse_ack(); tick(1);
      push("R8 other pair survives", 15, 'hFF, 1, 0, 'h8C + 4 * 255);
      tick(2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule